// File: doc/BRIEF.md
# Display Controller Register and Interrupt Bank

This block is the software-facing register bank of a display controller. A word-wide request port reads and writes configuration: the panel and layer sizes, the position and attributes of the graphics layer, the frame base address, and the background and colour-key values. It also holds an interrupt status and enable pair. The pixel pipeline raises status bits through an event input. The block drives a single level interrupt to the system.

Whenever software changes anything that affects the picture, the bank emits a one-cycle `invalidate` pulse. The pipeline uses this pulse to reload its configuration. Software can reset the whole bank by writing one configuration bit.

Size fields are kept internally as counts, so a field always holds at least one pixel or line. Software reads back the same value it wrote. Any request that is not a full, aligned word raises a sticky error flag and has no other effect. Addresses outside the map, including the video-layer window at 0x080 and above, read zero and ignore writes.

Top module: `dispctl_regs`

## Requirements
- R1: After reset, every register reads as follows:
  - the identity word at 0x000 reads 0x20, the fixed status word at 0x008 reads 1, and the line-status word at 0x02C reads 0x7FF;
  - the capability register at 0x018 reads 0x161;
  - the size registers read 0, and every other register reads 0;
  - `irq`, `invalidate` and `bus_err` are low.
- R2: The interrupt status register at 0x00C collects event bits. It is set by `evt[i]` high in a cycle. A write to it clears each bit that has a 1 in the data and leaves bits written with 0 unchanged. When an event and a clear hit the same bit in one cycle, the event wins.
- R3: The interrupt enable register at 0x010 keeps only the low 16 bits of the written data. `irq` is high exactly when any bit is set in both status and enable. It follows a write or an event from the next clock edge.
- R4: A write to the configuration register at 0x004 with data bit 1 set returns every register, and `bus_err`, to its reset value. The same write then stores its data under mask 0x301B into the configuration register. A write with bit 1 clear only stores the masked data.
- R5: The three size registers hold a pixel count field in bits 10:0 and a line count field in bits 26:16. They are the digital panel at 0x030, the LCD panel at 0x034 and the graphics layer at 0x038. Each field is stored as the written value plus one and read back as the stored count minus one, so a write of any field value, including 0 and 0x7FF, reads back unchanged.
- R6: The graphics position register at 0x03C keeps X in bits 10:0 and Y in bits 26:16 with no offset. Other bits read 0.
- R7: The two background colour registers (0x01C, 0x020) and the two colour-key registers (0x024, 0x028) keep 24 bits.
- R8: The remaining writable registers store their data under fixed masks:
  - the control register at 0x014 uses mask 0x07FF9FFF; bit 0 is the LCD output enable and bit 1 the digital output enable;
  - the capability register uses mask 0x3FF;
  - the graphics attribute register at 0x040 uses mask 0x7FF; bit 0 is the layer enable and bits 4:1 the pixel format;
  - the frame base register at 0x044 keeps all 32 bits.
- R9: `invalidate` is high for exactly the one cycle after an accepted write to a colour, size, position, attribute or base register. It stays low after writes to any other register.
- R10: A request with `be` not equal to 4'b1111, or with `addr[1:0]` not zero, sets the sticky `bus_err` flag. A read of this kind returns 0 on `rdata`. A write of this kind changes no register and raises no `invalidate`.
- R11: Read-only and unmapped addresses ignore writes. Reads of unmapped addresses return 0. `rdata` is registered and shows the read value from the clock edge that accepts the read, holding it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, one per cycle |
| wr | input | 1 | 1 = write, 0 = read |
| be | input | 4 | Byte enables; only 4'b1111 is a legal access |
| addr | input | 9 | Byte address within the bank |
| wdata | input | 32 | Write data |
| evt | input | 16 | Interrupt event bits from the pixel pipeline |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |
| invalidate | output | 1 | One-cycle configuration-changed pulse |
| bus_err | output | 1 | Sticky illegal-access flag |

## Verification
The assertions check the per-cycle rules on every cycle:
- an event with its enable set raises `irq`;
- clear writes drop only the bits they name, and unwritten status bits never fall;
- a soft reset drops `irq`;
- `bus_err` never falls except on soft reset;
- an illegal read returns zero;
- `invalidate` only follows a write;
- a size field reads back as written.

The exact register masks, the reset values, which addresses raise `invalidate`, the set-over-clear priority and the full reach of a soft reset can only be shown by the bench's write-then-read scenarios.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;
  // byte offsets of the register map
  localparam int OFF_ID     = 'h000;
  localparam int OFF_SYSC   = 'h004;
  localparam int OFF_SSTAT  = 'h008;
  localparam int OFF_ISTAT  = 'h00C;
  localparam int OFF_IEN    = 'h010;
  localparam int OFF_CTRL   = 'h014;
  localparam int OFF_CAPS   = 'h018;
  localparam int OFF_BG0    = 'h01C;
  localparam int OFF_BG1    = 'h020;
  localparam int OFF_KEY0   = 'h024;
  localparam int OFF_KEY1   = 'h028;
  localparam int OFF_LINE   = 'h02C;
  localparam int OFF_SZDIG  = 'h030;
  localparam int OFF_SZLCD  = 'h034;
  localparam int OFF_SZGFX  = 'h038;
  localparam int OFF_POS    = 'h03C;
  localparam int OFF_ATTR   = 'h040;
  localparam int OFF_BASE   = 'h044;

  localparam logic [31:0] MSK_SYSC = 32'h0000_301B;
  localparam logic [31:0] MSK_CTRL = 32'h07FF_9FFF;
  localparam logic [31:0] MSK_CAPS = 32'h0000_03FF;
  localparam logic [31:0] MSK_ATTR = 32'h0000_07FF;

  localparam logic [31:0] VAL_ID    = 32'h0000_0020;
  localparam logic [31:0] VAL_SSTAT = 32'h0000_0001;
  localparam logic [31:0] VAL_LINE  = 32'h0000_07FF;
  localparam logic [31:0] RST_CAPS  = 32'h0000_0161;

  localparam int SOFT_RST_BIT = 1;
endpackage

// File: rtl/dispctl_irq.sv
module dispctl_irq #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         stat_we,
  input  logic         en_we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] evt,
  output logic [N-1:0] stat,
  output logic [N-1:0] en,
  output logic         irq
);
  logic [N-1:0] stat_d, en_d;

  always_comb begin
    stat_d = stat;
    en_d   = en;
    if (clr) begin
      stat_d = '0;
      en_d   = '0;
    end else begin
      if (stat_we) stat_d = stat & ~wdata;
      stat_d = stat_d | evt;            // set wins over clear
      if (en_we) en_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      en   <= '0;
    end else begin
      stat <= stat_d;
      en   <= en_d;
    end
  end

  assign irq = |(stat & en);

  assert_evt_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & en) && !clr && !en_we) |=> irq);
  assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && !clr) |=> ((stat & $past(wdata) & ~$past(evt)) == '0));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_we && !clr) |=> ((stat & $past(stat)) == $past(stat)));
endmodule

// File: rtl/dispctl_szreg.sv
module dispctl_szreg #(
  parameter int FW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [FW-1:0] x_in,
  input  logic [FW-1:0] y_in,
  output logic [31:0]   rdval
);
  localparam int CW = FW + 1;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] x_q, y_q, x_d, y_d, x_m, y_m;

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    if (clr) begin
      x_d = ONE;
      y_d = ONE;
    end else if (we) begin
      x_d = CW'(x_in) + ONE;
      y_d = CW'(y_in) + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= ONE;
      y_q <= ONE;
    end else begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  assign x_m   = x_q - ONE;
  assign y_m   = y_q - ONE;
  assign rdval = (32'(y_m[FW-1:0]) << 16) | 32'(x_m[FW-1:0]);

  assert_size_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> (rdval[FW-1:0] == $past(x_in) && rdval[16+FW-1:16] == $past(y_in)));
endmodule

// File: rtl/dispctl_regs.sv
module dispctl_regs
  import dispctl_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int IRQ_N  = 16,
  parameter int SZ_W   = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [3:0]        be,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [IRQ_N-1:0]  evt,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic              invalidate,
  output logic              bus_err
);
  localparam int NCOL = 4;
  localparam int NSZ  = 3;
  localparam int COL_OFF [NCOL] = '{OFF_BG0, OFF_BG1, OFF_KEY0, OFF_KEY1};
  localparam int SZ_OFF  [NSZ]  = '{OFF_SZDIG, OFF_SZLCD, OFF_SZGFX};
  localparam logic [31:0] MSK_POS = (32'((1 << SZ_W) - 1) << 16) | 32'((1 << SZ_W) - 1);

  // access qualification
  logic acc_ok, wr_ok, rd_ok, bad;
  assign acc_ok = req && (be == 4'hF) && (addr[1:0] == 2'b00);
  assign wr_ok  = acc_ok && wr;
  assign rd_ok  = acc_ok && !wr;
  assign bad    = req && !acc_ok;

  logic sysc_we, stat_we, en_we, ctrl_we, caps_we, pos_we, attr_we, base_we, soft_clr;
  assign sysc_we  = wr_ok && addr == ADDR_W'(OFF_SYSC);
  assign stat_we  = wr_ok && addr == ADDR_W'(OFF_ISTAT);
  assign en_we    = wr_ok && addr == ADDR_W'(OFF_IEN);
  assign ctrl_we  = wr_ok && addr == ADDR_W'(OFF_CTRL);
  assign caps_we  = wr_ok && addr == ADDR_W'(OFF_CAPS);
  assign pos_we   = wr_ok && addr == ADDR_W'(OFF_POS);
  assign attr_we  = wr_ok && addr == ADDR_W'(OFF_ATTR);
  assign base_we  = wr_ok && addr == ADDR_W'(OFF_BASE);
  assign soft_clr = sysc_we && wdata[SOFT_RST_BIT];

  // interrupt pair
  logic [IRQ_N-1:0] stat_q, en_q;
  dispctl_irq #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .stat_we(stat_we), .en_we(en_we),
    .wdata(wdata[IRQ_N-1:0]), .evt(evt), .stat(stat_q), .en(en_q), .irq(irq)
  );

  // colour registers
  logic [23:0]     col_q [NCOL];
  logic [NCOL-1:0] col_we;
  for (genvar g = 0; g < NCOL; g++) begin : g_col
    logic [23:0] col_d;
    assign col_we[g] = wr_ok && addr == ADDR_W'(COL_OFF[g]);
    always_comb begin
      col_d = col_q[g];
      if (soft_clr)       col_d = '0;
      else if (col_we[g]) col_d = wdata[23:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) col_q[g] <= '0;
      else        col_q[g] <= col_d;
    end
  end

  // size registers (minus-one encoding)
  logic [31:0]    sz_rd [NSZ];
  logic [NSZ-1:0] sz_we;
  for (genvar g = 0; g < NSZ; g++) begin : g_sz
    assign sz_we[g] = wr_ok && addr == ADDR_W'(SZ_OFF[g]);
    dispctl_szreg #(.FW(SZ_W)) u_sz (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr), .we(sz_we[g]),
      .x_in(wdata[SZ_W-1:0]), .y_in(wdata[16+SZ_W-1:16]), .rdval(sz_rd[g])
    );
  end

  // plain registers: next state
  logic [31:0] sysc_q, ctrl_q, caps_q, pos_q, attr_q, base_q, rdata_q, rd_val;
  logic [31:0] sysc_d, ctrl_d, caps_d, pos_d, attr_d, base_d, rdata_d;
  logic        inv_q, inv_d, err_q, err_d;

  always_comb begin
    sysc_d = sysc_q;  ctrl_d = ctrl_q;  caps_d = caps_q;
    pos_d  = pos_q;   attr_d = attr_q;  base_d = base_q;
    if (soft_clr) begin
      ctrl_d = '0; caps_d = RST_CAPS; pos_d = '0; attr_d = '0; base_d = '0;
    end else begin
      if (ctrl_we) ctrl_d = wdata & MSK_CTRL;
      if (caps_we) caps_d = wdata & MSK_CAPS;
      if (pos_we)  pos_d  = wdata & MSK_POS;
      if (attr_we) attr_d = wdata & MSK_ATTR;
      if (base_we) base_d = wdata;
    end
    if (sysc_we) sysc_d = wdata & MSK_SYSC;
    inv_d = (|col_we) || (|sz_we) || pos_we || attr_we || base_we;
    err_d = soft_clr ? 1'b0 : (err_q || bad);
  end

  // read mux
  always_comb begin
    rd_val = '0;
    case (addr)
      ADDR_W'(OFF_ID):    rd_val = VAL_ID;
      ADDR_W'(OFF_SYSC):  rd_val = sysc_q;
      ADDR_W'(OFF_SSTAT): rd_val = VAL_SSTAT;
      ADDR_W'(OFF_ISTAT): rd_val = 32'(stat_q);
      ADDR_W'(OFF_IEN):   rd_val = 32'(en_q);
      ADDR_W'(OFF_CTRL):  rd_val = ctrl_q;
      ADDR_W'(OFF_CAPS):  rd_val = caps_q;
      ADDR_W'(OFF_LINE):  rd_val = VAL_LINE;
      ADDR_W'(OFF_POS):   rd_val = pos_q;
      ADDR_W'(OFF_ATTR):  rd_val = attr_q;
      ADDR_W'(OFF_BASE):  rd_val = base_q;
      default:            rd_val = '0;
    endcase
    for (int i = 0; i < NCOL; i++)
      if (addr == ADDR_W'(COL_OFF[i])) rd_val = 32'(col_q[i]);
    for (int i = 0; i < NSZ; i++)
      if (addr == ADDR_W'(SZ_OFF[i])) rd_val = sz_rd[i];
    rdata_d = rdata_q;
    if (rd_ok)            rdata_d = rd_val;
    else if (bad && !wr)  rdata_d = '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sysc_q <= '0; ctrl_q <= '0; caps_q <= RST_CAPS; pos_q <= '0;
      attr_q <= '0; base_q <= '0; rdata_q <= '0; inv_q <= 1'b0; err_q <= 1'b0;
    end else begin
      sysc_q <= sysc_d; ctrl_q <= ctrl_d; caps_q <= caps_d; pos_q <= pos_d;
      attr_q <= attr_d; base_q <= base_d; rdata_q <= rdata_d;
      inv_q  <= inv_d;  err_q  <= err_d;
    end
  end

  assign rdata      = rdata_q;
  assign invalidate = inv_q;
  assign bus_err    = err_q;

  assert_inv_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    invalidate |-> $past(req && wr && be == 4'hF));
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !soft_clr) |=> bus_err);
  assert_bad_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr && be != 4'hF) |=> rdata == '0);
  assert_soft_clr_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> !irq);
endmodule

// File: tb/dispctl_regs_test.sv
module dispctl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [3:0]  be = 4'hF;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] evt = '0;
  logic [31:0] rdata;
  logic        irq, invalidate, bus_err;
  logic        inv_seen;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dispctl_regs uut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .be(be), .addr(addr),
    .wdata(wdata), .evt(evt), .rdata(rdata), .irq(irq),
    .invalidate(invalidate), .bus_err(bus_err)
  );

  typedef struct packed {
    logic [8:0]  a;
    logic [31:0] w;
    logic [31:0] e;
    logic        inv;
    logic [7:0]  rq;
  } vec_t;

  // write value, read back expected, expected invalidate, requirement number
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{9'h014, 32'hFFFF_FFFF, 32'h07FF_9FFF, 1'b0, 8'd8},   // R8 control mask
    '{9'h018, 32'hFFFF_FFFF, 32'h0000_03FF, 1'b0, 8'd8},   // R8 capability mask
    '{9'h040, 32'h0000_FFFF, 32'h0000_07FF, 1'b1, 8'd8},   // R8 attribute mask
    '{9'h044, 32'hDEAD_BEEC, 32'hDEAD_BEEC, 1'b1, 8'd8},   // R8 base
    '{9'h01C, 32'hAB12_3456, 32'h0012_3456, 1'b1, 8'd7},   // R7 background
    '{9'h028, 32'hFFFF_FFFF, 32'h00FF_FFFF, 1'b1, 8'd7},   // R7 key
    '{9'h030, 32'h0123_0456, 32'h0123_0456, 1'b1, 8'd5},   // R5 digital size
    '{9'h034, 32'hFFFF_FFFF, 32'h07FF_07FF, 1'b1, 8'd5},   // R5 max field
    '{9'h038, 32'h0000_0000, 32'h0000_0000, 1'b1, 8'd5},   // R5 zero field
    '{9'h03C, 32'hF8AA_F855, 32'h00AA_0055, 1'b1, 8'd6},   // R6 position
    '{9'h010, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 8'd3},   // R3 enable mask
    '{9'h004, 32'hFFFF_FFFD, 32'h0000_3019, 1'b0, 8'd4},   // R4 sysconfig no reset
    '{9'h000, 32'h0000_0000, 32'h0000_0020, 1'b0, 8'd11},  // R11 read-only id
    '{9'h02C, 32'h0000_0000, 32'h0000_07FF, 1'b0, 8'd11},  // R11 read-only line status
    '{9'h100, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 8'd11},  // R11 video window
    '{9'h1FC, 32'h1234_5678, 32'h0000_0000, 1'b0, 8'd11}   // R11 unmapped
  };

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [8:0] a, input logic [31:0] d,
                     input logic [3:0] b, input logic [15:0] e);
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d; be = b; evt = e;
    @(posedge clk); #1;
    inv_seen = invalidate;
    req = 1'b0; evt = '0; be = 4'hF;
  endtask

  task automatic wr_reg(input logic [8:0] a, input logic [31:0] d);
    bus(1'b1, a, d, 4'hF, 16'h0);
  endtask

  task automatic rd_reg(input logic [8:0] a, output logic [31:0] v);
    bus(1'b0, a, 32'h0, 4'hF, 16'h0);
    v = rdata;
  endtask

  task automatic pulse_evt(input logic [15:0] e);
    @(negedge clk); evt = e;
    @(posedge clk); #1; evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 invalidate", 32'(invalidate), 0);
    chk("R1 bus_err", 32'(bus_err), 0);
    rd_reg(9'h000, v); chk("R1 id", v, 32'h20);
    rd_reg(9'h008, v); chk("R1 fixed status", v, 32'h1);
    rd_reg(9'h02C, v); chk("R1 line status", v, 32'h7FF);
    rd_reg(9'h018, v); chk("R1 capability", v, 32'h161);
    rd_reg(9'h034, v); chk("R1 lcd size", v, 32'h0);
    rd_reg(9'h014, v); chk("R1 control", v, 32'h0);
    rd_reg(9'h00C, v); chk("R1 status", v, 32'h0);

    // table walk: write, check invalidate pulse, read back
    for (int i = 0; i < NV; i++) begin
      wr_reg(VECS[i].a, VECS[i].w);
      checks++;
      if (inv_seen !== VECS[i].inv) begin
        errors++;
        $display("FAIL R9 (vector %0d, R%0d) invalidate actual=%b expected=%b",
                 i, VECS[i].rq, inv_seen, VECS[i].inv);
      end
      rd_reg(VECS[i].a, v);
      checks++;
      if (v !== VECS[i].e) begin
        errors++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h", VECS[i].rq, i, v, VECS[i].e);
      end
    end

    // R9 pulse lasts one cycle
    wr_reg(9'h020, 32'h0000_00AA);
    chk("R9 pulse high", 32'(inv_seen), 1);
    @(posedge clk); #1;
    chk("R9 pulse one cycle", 32'(invalidate), 0);

    // R2 / R3 interrupt behaviour (enable currently 0xFFFF)
    pulse_evt(16'h0005);
    chk("R3 irq on event", 32'(irq), 1);
    rd_reg(9'h00C, v); chk("R2 status set", v, 32'h5);
    wr_reg(9'h010, 32'h2);
    chk("R3 irq masked", 32'(irq), 0);
    wr_reg(9'h010, 32'h1);
    chk("R3 irq enabled", 32'(irq), 1);
    wr_reg(9'h00C, 32'h1);
    chk("R3 irq after clear", 32'(irq), 0);
    rd_reg(9'h00C, v); chk("R2 write-one-clear", v, 32'h4);
    bus(1'b1, 9'h00C, 32'hC, 4'hF, 16'h0008);
    rd_reg(9'h00C, v); chk("R2 set wins over clear", v, 32'h8);
    wr_reg(9'h00C, 32'h0);
    rd_reg(9'h00C, v); chk("R2 zero write keeps", v, 32'h8);

    // R10 illegal accesses
    bus(1'b1, 9'h014, 32'h0, 4'h1, 16'h0);
    chk("R10 bus_err set", 32'(bus_err), 1);
    rd_reg(9'h014, v); chk("R10 partial write ignored", v, 32'h07FF_9FFF);
    bus(1'b1, 9'h01C, 32'h0, 4'h3, 16'h0);
    chk("R10 no invalidate", 32'(inv_seen), 0);
    rd_reg(9'h01C, v); chk("R10 colour kept", v, 32'h0012_3456);
    bus(1'b0, 9'h018, 32'h0, 4'hE, 16'h0);
    chk("R10 partial read zero", rdata, 32'h0);
    bus(1'b1, 9'h015, 32'h0, 4'hF, 16'h0);
    rd_reg(9'h014, v); chk("R10 misaligned ignored", v, 32'h07FF_9FFF);
    chk("R10 bus_err sticky", 32'(bus_err), 1);

    // R4 soft reset
    wr_reg(9'h004, 32'h0000_0002);
    chk("R4 irq cleared", 32'(irq), 0);
    chk("R4 bus_err cleared", 32'(bus_err), 0);
    rd_reg(9'h004, v); chk("R4 sysconfig stored", v, 32'h2);
    rd_reg(9'h014, v); chk("R4 control reset", v, 32'h0);
    rd_reg(9'h018, v); chk("R4 capability reset", v, 32'h161);
    rd_reg(9'h034, v); chk("R4 size reset", v, 32'h0);
    rd_reg(9'h00C, v); chk("R4 status reset", v, 32'h0);
    rd_reg(9'h010, v); chk("R4 enable reset", v, 32'h0);
    rd_reg(9'h01C, v); chk("R4 colour reset", v, 32'h0);
    rd_reg(9'h044, v); chk("R4 base reset", v, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule